// File: doc/BRIEF.md
# Iterative SHA-1 Block Compression Engine

This block runs the SHA-1 compression function over one 512-bit block that the caller has already padded. It performs one round per clock. A small state machine sequences the work. A five-word working state is updated eighty times. The message schedule is rebuilt on the fly in a sliding window of sixteen words. A final fold cycle adds the working state into the five-word chaining value, and the 160-bit digest output shows that chaining value.

Two command strobes start a block:

- `cmd_new_i` begins a fresh hash from the standard initial chaining value.
- `cmd_cont_i` resumes from whatever chaining value the previous block left.

Long messages are hashed by issuing `cmd_new_i` for the first block and `cmd_cont_i` for each later block, waiting for `rdy_o` between blocks. Padding and length encoding are the caller's job.

States:

- ST_IDLE: waiting for a command.
- ST_ROUND: eighty compression rounds.
- ST_FOLD: one cycle that adds the working state into the chaining value.

Transitions:

- IDLE→ROUND: a command is accepted in ST_IDLE.
- ROUND→ROUND: the round counter is below 79.
- ROUND→FOLD: round 79 completes.
- FOLD→IDLE: unconditional.

Top module: `sha1_iter_core`

## Requirements
- R1: After reset, `rdy_o` is 1, `dvalid_o` is 0 and `digest_o` holds the initial chaining value 67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0. The first word occupies bits 159:128.
- R2: A command seen while `rdy_o` is 1 is accepted. In the cycle after acceptance, `rdy_o` and `dvalid_o` are both 0. For `cmd_new_i`, `digest_o` then already shows the initial chaining value. For `cmd_cont_i`, `digest_o` is unchanged.
- R3: `rdy_o` returns to 1 exactly 81 cycles after the accepting clock edge. `dvalid_o` rises in that same cycle.
- R4: `cmd_new_i` with the padded one-block message "abc" yields a9993e364706816aba3e25717850c26c9cd0d89d. Block word 0 is `blk_i[511:480]`.
- R5: For the 56-byte two-block test message, `cmd_new_i` on the first block yields f4286818c37b27ae0408f581846771484a566572. `cmd_cont_i` on the second block, which carries length 0x1C0, then yields 84983e441c3bd26ebaae4aa1f95129e5e54670f1.
- R6: For arbitrary blocks and arbitrary sequences of new and continued hashes, each digest equals the SHA-1 compression of the block with the applicable chaining value. That compression uses 80 rounds, four function/constant groups and the XOR-rotate schedule.
- R7: Strobes and `blk_i` changes while `rdy_o` is 0 are ignored. The latency stays 81 cycles, the digest is that of the block presented at acceptance, and `digest_o` does not change during processing.
- R8: When both strobes are high in the same cycle, the fresh-hash command wins.
- R9: After completion, `dvalid_o` and `digest_o` hold steady in idle until the next accepted command.
- R10: `cmd_cont_i` issued straight after reset chains from the initial value, so it gives the same digest as `cmd_new_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_new_i | input | 1 | Start a fresh hash on `blk_i` |
| cmd_cont_i | input | 1 | Continue the hash on `blk_i` |
| blk_i | input | 512 | Padded message block, word 0 in the top bits |
| rdy_o | output | 1 | Engine idle, able to accept a command |
| dvalid_o | output | 1 | `digest_o` holds a freshly completed digest |
| digest_o | output | 160 | Chaining value H0..H4, H0 in the top bits |

## Verification
A corrupted schedule word, round constant or function choice stays hidden until the fold. It then shows as a completely different 160-bit digest at the end of the 81-cycle window. The known vectors and the randomly chained blocks catch this at the first completion after the fault. A wrong round counter or state machine shows earlier, as a latency other than 81 cycles or a `dvalid_o` that disagrees with `rdy_o`. A chaining-register fault shows only on the next `cmd_cont_i` block, which is why the random sequence mixes continued blocks with fresh ones.

// File: rtl/sha1_core_pkg.sv
package sha1_core_pkg;

    localparam int WORD_W  = 32;
    localparam int N_WORDS = 5;
    localparam int ROUNDS  = 80;
    localparam int BLK_W   = 16 * WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } state5_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROUND = 2'd1,
        ST_FOLD  = 2'd2
    } phase_e;

    localparam state5_t IV = '{
        a: 32'h67452301,
        b: 32'hEFCDAB89,
        c: 32'h98BADCFE,
        d: 32'h10325476,
        e: 32'hC3D2E1F0
    };

    localparam word_t K_GRP0 = 32'h5A827999;
    localparam word_t K_GRP1 = 32'h6ED9EBA1;
    localparam word_t K_GRP2 = 32'h8F1BBCDC;
    localparam word_t K_GRP3 = 32'hCA62C1D6;

    function automatic word_t rotl(input word_t x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

endpackage

// File: rtl/sha1_msg_window.sv
module sha1_msg_window
    import sha1_core_pkg::*;
#(
    parameter int NW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 shift,
    input  logic [NW*WORD_W-1:0] blk_i,
    output word_t                w_o
);
    localparam int TAP3  = NW - 3;
    localparam int TAP8  = NW - 8;
    localparam int TAP14 = NW - 14;

    word_t win [NW];
    word_t fresh;

    always_comb begin
        fresh = rotl(win[TAP3] ^ win[TAP8] ^ win[TAP14] ^ win[0], 1);
    end

    assign w_o = win[0];

    for (genvar i = 0; i < NW; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                win[i] <= '0;
            end else if (load) begin
                win[i] <= blk_i[(NW-1-i)*WORD_W +: WORD_W];
            end else if (shift) begin
                if (i == NW - 1) begin
                    win[i] <= fresh;
                end else begin
                    win[i] <= win[i+1];
                end
            end
        end
    end

endmodule

// File: rtl/sha1_round_fn.sv
module sha1_round_fn
    import sha1_core_pkg::*;
#(
    parameter int NR    = ROUNDS,
    parameter int CNT_W = $clog2(NR)
) (
    input  state5_t          cur_i,
    input  word_t            w_i,
    input  logic [CNT_W-1:0] rnd_i,
    output state5_t          nxt_o
);
    localparam int GRP = NR / 4;

    word_t f;
    word_t k;
    word_t t;

    always_comb begin
        if (rnd_i < CNT_W'(GRP)) begin
            f = (cur_i.b & cur_i.c) | (~cur_i.b & cur_i.d);
            k = K_GRP0;
        end else if (rnd_i < CNT_W'(2 * GRP)) begin
            f = cur_i.b ^ cur_i.c ^ cur_i.d;
            k = K_GRP1;
        end else if (rnd_i < CNT_W'(3 * GRP)) begin
            f = (cur_i.b & cur_i.c) | (cur_i.b & cur_i.d) | (cur_i.c & cur_i.d);
            k = K_GRP2;
        end else begin
            f = cur_i.b ^ cur_i.c ^ cur_i.d;
            k = K_GRP3;
        end
        t = rotl(cur_i.a, 5) + f + cur_i.e + k + w_i;
        nxt_o.a = t;
        nxt_o.b = cur_i.a;
        nxt_o.c = rotl(cur_i.b, 30);
        nxt_o.d = cur_i.c;
        nxt_o.e = cur_i.d;
    end

endmodule

// File: rtl/sha1_chain_regs.sv
module sha1_chain_regs
    import sha1_core_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load_iv,
    input  logic    fold,
    input  state5_t work_i,
    output state5_t h_o
);
    logic [N_WORDS*WORD_W-1:0] h_q;
    logic [N_WORDS*WORD_W-1:0] w_flat;
    logic [N_WORDS*WORD_W-1:0] iv_flat;

    assign w_flat  = work_i;
    assign iv_flat = IV;

    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                h_q[i*WORD_W +: WORD_W] <= iv_flat[i*WORD_W +: WORD_W];
            end else if (load_iv) begin
                h_q[i*WORD_W +: WORD_W] <= iv_flat[i*WORD_W +: WORD_W];
            end else if (fold) begin
                h_q[i*WORD_W +: WORD_W] <= h_q[i*WORD_W +: WORD_W]
                                         + w_flat[i*WORD_W +: WORD_W];
            end
        end
    end

    assign h_o = h_q;

endmodule

// File: rtl/sha1_iter_core.sv
module sha1_iter_core
    import sha1_core_pkg::*;
#(
    parameter int NR = ROUNDS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_new_i,
    input  logic         cmd_cont_i,
    input  logic [511:0] blk_i,
    output logic         rdy_o,
    output logic         dvalid_o,
    output logic [159:0] digest_o
);
    localparam int CNT_W = $clog2(NR);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NR - 1);

    phase_e           state_q;
    phase_e           state_n;
    logic [CNT_W-1:0] rnd_q;
    state5_t          work_q;
    state5_t          work_nxt;
    state5_t          h_cur;
    word_t            w_cur;
    logic             accept;
    logic             load_iv;
    logic             in_round;
    logic             in_fold;
    logic             valid_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // next state and control outputs
    always_comb begin
        state_n  = state_q;
        accept   = 1'b0;
        load_iv  = 1'b0;
        in_round = 1'b0;
        in_fold  = 1'b0;
        rdy_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rdy_o = 1'b1;
                if (cmd_new_i || cmd_cont_i) begin
                    accept  = 1'b1;
                    load_iv = cmd_new_i;
                    state_n = ST_ROUND;
                end
            end
            ST_ROUND: begin
                in_round = 1'b1;
                if (rnd_q == LAST) begin
                    state_n = ST_FOLD;
                end
            end
            ST_FOLD: begin
                in_fold = 1'b1;
                state_n = ST_IDLE;
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase
    end

    sha1_msg_window #(.NW(16)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .shift (in_round),
        .blk_i (blk_i),
        .w_o   (w_cur)
    );

    sha1_round_fn #(.NR(NR), .CNT_W(CNT_W)) u_round (
        .cur_i (work_q),
        .w_i   (w_cur),
        .rnd_i (rnd_q),
        .nxt_o (work_nxt)
    );

    sha1_chain_regs u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_iv (load_iv),
        .fold    (in_fold),
        .work_i  (work_q),
        .h_o     (h_cur)
    );

    // working state, round counter, completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q  <= '0;
            rnd_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            if (accept) begin
                work_q  <= load_iv ? IV : h_cur;
                rnd_q   <= '0;
                valid_q <= 1'b0;
            end else if (in_round) begin
                work_q <= work_nxt;
                rnd_q  <= rnd_q + 1'b1;
            end else if (in_fold) begin
                valid_q <= 1'b1;
            end
        end
    end

    assign dvalid_o = valid_q;
    assign digest_o = h_cur;

endmodule

// File: rtl/sha1_iter_core_chk.sv
module sha1_iter_core_chk
    import sha1_core_pkg::*;
#(
    parameter int NR = ROUNDS
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmd_new_i,
    input logic         cmd_cont_i,
    input logic         rdy_o,
    input logic         dvalid_o,
    input logic [159:0] digest_o
);
    localparam int RUN_W = $clog2(NR + 2) + 1;
    localparam logic [RUN_W-1:0] SPAN = RUN_W'(NR + 1);

    logic [RUN_W-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (rdy_o) begin
            busy_run <= '0;
        end else begin
            busy_run <= busy_run + 1'b1;
        end
    end

    assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && (cmd_new_i || cmd_cont_i)) |=> (!rdy_o && !dvalid_o));

    assert_init_shows_iv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && cmd_new_i) |=> (digest_o == 160'(IV)));

    assert_latency_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= SPAN);

    assert_latency_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> (busy_run == SPAN));

    assert_valid_with_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dvalid_o) |-> $rose(rdy_o));

    assert_no_valid_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_o |-> !dvalid_o);

    assert_digest_hold_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_o && !$past(rdy_o)) |-> $stable(digest_o));

    assert_digest_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && $past(rdy_o) && !$past(cmd_new_i)) |-> $stable(digest_o));

endmodule

bind sha1_iter_core sha1_iter_core_chk #(.NR(NR)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_new_i  (cmd_new_i),
    .cmd_cont_i (cmd_cont_i),
    .rdy_o      (rdy_o),
    .dvalid_o   (dvalid_o),
    .digest_o   (digest_o)
);

// File: tb/sha1_iter_core_tb_top.sv
module sha1_iter_core_tb_top;

    localparam logic [159:0] IV_EXP = 160'h67452301EFCDAB8998BADCFE10325476C3D2E1F0;
    localparam logic [511:0] BLK_ABC =
        512'h61626380000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000000018;
    localparam logic [159:0] DG_ABC = 160'ha9993e364706816aba3e25717850c26c9cd0d89d;
    localparam logic [511:0] BLK_L1 =
        512'h6162636462636465636465666465666765666768666768696768696A68696A6B696A6B6C6A6B6C6D6B6C6D6E6C6D6E6F6D6E6F706E6F70718000000000000000;
    localparam logic [159:0] DG_L1 = 160'hf4286818c37b27ae0408f581846771484a566572;
    localparam logic [511:0] BLK_L2 = 512'h1C0;
    localparam logic [159:0] DG_L2 = 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_new_i = 1'b0;
    logic         cmd_cont_i = 1'b0;
    logic [511:0] blk_i = '0;
    logic         rdy_o;
    logic         dvalid_o;
    logic [159:0] digest_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    sha1_iter_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_new_i  (cmd_new_i),
        .cmd_cont_i (cmd_cont_i),
        .blk_i      (blk_i),
        .rdy_o      (rdy_o),
        .dvalid_o   (dvalid_o),
        .digest_o   (digest_o)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [159:0] ref_compress(input logic [159:0] hin,
                                                  input logic [511:0] blk);
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, k, t;
        for (int i = 0; i < 16; i++) w[i] = blk[511 - 32*i -: 32];
        for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
        {a, b, c, d, e} = hin;
        for (int i = 0; i < 80; i++) begin
            case (i / 20)
                0: begin f = (b & c) | (~b & d); k = 32'h5A827999; end
                1: begin f = b ^ c ^ d; k = 32'h6ED9EBA1; end
                2: begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
                default: begin f = b ^ c ^ d; k = 32'hCA62C1D6; end
            endcase
            t = rl(a, 5) + f + e + k + w[i];
            e = d; d = c; c = rl(b, 30); b = a; a = t;
        end
        return {hin[159:128] + a, hin[127:96] + b, hin[95:64] + c,
                hin[63:32] + d, hin[31:0] + e};
    endfunction

    task automatic check(input string tag, input bit ok,
                         input logic [159:0] act, input logic [159:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // poke_at < 0 means no disturbance while busy
    task automatic run_block(input bit use_new, input bit use_both,
                             input logic [511:0] blk, input int poke_at,
                             input logic [159:0] prev_dg,
                             output logic [159:0] dg, output int lat);
        @(negedge clk);
        blk_i      = blk;
        cmd_new_i  = use_new | use_both;
        cmd_cont_i = !use_new | use_both;
        @(negedge clk);
        cmd_new_i  = 1'b0;
        cmd_cont_i = 1'b0;
        check("R2 busy after accept", !rdy_o && !dvalid_o,
              {158'd0, rdy_o, dvalid_o}, 160'd0);
        if (use_new || use_both)
            check("R2 iv loaded", digest_o == IV_EXP, digest_o, IV_EXP);
        else
            check("R2 chain kept", digest_o == prev_dg, digest_o, prev_dg);
        lat = 0;
        while (!rdy_o) begin
            if (lat == poke_at) begin
                cmd_cont_i = 1'b1;
                cmd_new_i  = 1'b1;
                blk_i      = ~blk;
            end
            @(negedge clk);
            cmd_cont_i = 1'b0;
            cmd_new_i  = 1'b0;
            lat++;
        end
        dg = digest_o;
        check("R3 latency", lat == 81, 160'(lat), 160'd81);
        check("R3 valid with ready", dvalid_o == 1'b1, {159'd0, dvalid_o}, 160'd1);
    endtask

    initial begin
        logic [159:0] dg;
        logic [159:0] chain;
        logic [511:0] rb;
        int           lat;
        bit           fresh;

        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1
        check("R1 reset ready", rdy_o == 1'b1, {159'd0, rdy_o}, 160'd1);
        check("R1 reset valid", dvalid_o == 1'b0, {159'd0, dvalid_o}, 160'd0);
        check("R1 reset digest", digest_o == IV_EXP, digest_o, IV_EXP);

        // R10: continue straight after reset
        run_block(1'b0, 1'b0, BLK_ABC, -1, IV_EXP, dg, lat);
        check("R10 cont from reset", dg == DG_ABC, dg, DG_ABC);

        // R4
        run_block(1'b1, 1'b0, BLK_ABC, -1, dg, dg, lat);
        check("R4 abc digest", dg == DG_ABC, dg, DG_ABC);

        // R5
        run_block(1'b1, 1'b0, BLK_L1, -1, dg, dg, lat);
        check("R5 first block", dg == DG_L1, dg, DG_L1);
        run_block(1'b0, 1'b0, BLK_L2, -1, dg, dg, lat);
        check("R5 second block", dg == DG_L2, dg, DG_L2);

        // R9: hold in idle
        repeat (6) @(negedge clk);
        check("R9 valid held", dvalid_o == 1'b1, {159'd0, dvalid_o}, 160'd1);
        check("R9 digest held", digest_o == DG_L2, digest_o, DG_L2);

        // R7: strobes and block changes while busy
        run_block(1'b1, 1'b0, BLK_ABC, 10, dg, dg, lat);
        check("R7 poke early", dg == DG_ABC, dg, DG_ABC);
        run_block(1'b0, 1'b0, BLK_L2, 79, dg, dg, lat);
        check("R7 poke late", dg == ref_compress(DG_ABC, BLK_L2), dg,
              ref_compress(DG_ABC, BLK_L2));

        // R8: both strobes, chain not at IV
        run_block(1'b0, 1'b1, BLK_ABC, -1, dg, dg, lat);
        check("R8 new wins", dg == DG_ABC, dg, DG_ABC);

        // R6: random blocks, mixed fresh and continued
        chain = dg;
        for (int it = 0; it < 14; it++) begin
            for (int j = 0; j < 16; j++) rb[j*32 +: 32] = $urandom;
            fresh = ($urandom % 3) == 0;
            run_block(fresh, 1'b0, rb, -1, chain, dg, lat);
            chain = ref_compress(fresh ? IV_EXP : chain, rb);
            check("R6 random block", dg == chain, dg, chain);
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule